// File: doc/BRIEF.md
# Expansion ROM Byte-Gathering Read Sequencer

This block serves a 32-bit host read of an expansion ROM that sits behind an 8-bit external bus. When a read request arrives and both enables are set, the block drives a low ROM address byte. It waits a run-time number of clocks and samples the 8-bit data input. The same edge that takes the byte also puts out the next address. After four bytes the holding registers form one little-endian word, and a one-cycle target-ready returns it to the host logic.

The wait per byte comes from a 4-bit timing register. That register resets to 9 and is written through a simple write strobe. Its value is copied when an access starts, so a write made during an access takes effect from the next access on. If the host flagged the read as a burst, the block completes the first data phase only. In the cycle after target-ready it then signals a disconnect for one cycle.

Top module: `xrom_rd_seq`

## Requirements
- R1: The timing register `tmg` resets to 9 and takes `tmg_wd_i` on any edge where `tmg_we_i` is high. With the reset value, the first byte is sampled on the 10th rising edge after the request edge.
- R2: With a timing value N (0 to 15), byte k (k = 0..3) is sampled from `ebd_i` on the rising edge (k+1)(N+1) after the edge that accepted the request.
- R3: After the accepting edge, `eba_o` equals `{word_addr_i, 2'b00}`. Each of the first three sample edges adds 1 to bits [1:0] only. Bits [7:2] never change during the access, and the last sample edge leaves `eba_o` unchanged.
- R4: `rdata_o` is little-endian: byte 0 (offset 0) is in bits [7:0] and byte 3 (offset 3) is in bits [31:24]. It is valid while `trdy_o` is high.
- R5: `trdy_o` is a one-cycle pulse. It rises on the edge right after the last sample edge, which is edge 4(N+1)+1 after the accepting edge (edge 41 at the reset timing).
- R6: `rom_cs_o` rises on the accepting edge, stays high through all four fetches, and is low in the cycle where `trdy_o` is high.
- R7: If `burst_i` was high with the accepted request, `stop_o` is high for exactly the one cycle after `trdy_o`, and `trdy_o` is low in that cycle. Without a burst, `stop_o` stays low.
- R8: A request is accepted only while `mem_en_i` and `rom_en_i` are both 1. Otherwise it causes no chip select, no `trdy_o` and no `stop_o`.
- R9: A write to the timing register during an access does not change the timing of that access. It does apply to the next access.
- R10: Requests that arrive while an access is in progress are dropped. They change neither the data nor the timing of that access, and they start nothing after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_en_i | input | 1 | Memory-space enable |
| rom_en_i | input | 1 | ROM decode enable |
| tmg_we_i | input | 1 | Timing register write strobe |
| tmg_wd_i | input | 4 | Timing register write data (wait clocks N) |
| req_i | input | 1 | Host read request, sampled when idle |
| burst_i | input | 1 | Host intends more data phases |
| word_addr_i | input | 6 | Dword part of the ROM low address |
| ebd_i | input | 8 | External data bus |
| eba_o | output | 8 | External low address byte |
| rom_cs_o | output | 1 | ROM chip select |
| trdy_o | output | 1 | Target ready, read data valid |
| stop_o | output | 1 | Disconnect of a burst at its second data phase |
| rdata_o | output | 32 | Assembled read word |

## Verification
The bench ROM model returns valid data only in the last cycle before the intended sample edge and puts 0xEE on the bus at all other times. A sequencer that samples one clock early or late therefore returns corrupt bytes, and a wrong wait count also moves the target-ready cycle. The bench runs the timing at 0, 3, 9 and 15, and it accesses address 0xFC so that a carry out of the low bits would change the high address bits. It also writes the timing register in the middle of an access and issues a second request while the sequencer is busy. A design that reloads the wait from the live register, or that queues the extra request, produces a shifted ready cycle or a second chip select. Bursts must end with a single disconnect cycle and no second ready, and each disabled enable combination must leave the bus quiet.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LAST,
    ST_RESP,
    ST_DISC
  } seq_st_e;
endpackage

// File: rtl/xrom_tmg_reg.sv
module xrom_tmg_reg #(
  parameter int TMG_W   = 4,
  parameter int TMG_RST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TMG_W-1:0] wd_i,
  output logic [TMG_W-1:0] tmg_o
);
  logic [TMG_W-1:0] tmg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmg_q <= TMG_W'(TMG_RST);
    else if (we_i) tmg_q <= wd_i;
  end

  assign tmg_o = tmg_q;

  AST_TMG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> tmg_o == $past(tmg_o)); // R1
endmodule

// File: rtl/xrom_wait_ctr.sv
module xrom_wait_ctr #(
  parameter int TMG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMG_W-1:0] reload_i,
  input  logic             run_i,
  output logic             strobe_o
);
  logic [TMG_W-1:0] cnt_q;
  logic [TMG_W-1:0] reload_q;

  // reload value frozen per access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= reload_i;
      reload_q <= reload_i;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign strobe_o = run_i && (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= reload_q); // R2
  AST_RELOAD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> reload_q == $past(reload_q)); // R9
endmodule

// File: rtl/xrom_byte_gather.sv
module xrom_byte_gather #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q <= '0;
      else if (cap_i && idx_i == IDX_W'(g))      lane_q <= byte_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> word_o == $past(word_o)); // R4
endmodule

// File: rtl/xrom_rd_seq.sv
module xrom_rd_seq
  import xrom_pkg::*;
#(
  parameter int TMG_W   = 4,
  parameter int TMG_RST = 9,
  parameter int ADDR_W  = 8,
  parameter int BYTE_W  = 8,
  parameter int NBYTES  = 4,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int WORD_W = BYTE_W * NBYTES,
  localparam int WA_W   = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_en_i,
  input  logic              rom_en_i,
  input  logic              tmg_we_i,
  input  logic [TMG_W-1:0]  tmg_wd_i,
  input  logic              req_i,
  input  logic              burst_i,
  input  logic [WA_W-1:0]   word_addr_i,
  input  logic [BYTE_W-1:0] ebd_i,
  output logic [ADDR_W-1:0] eba_o,
  output logic              rom_cs_o,
  output logic              trdy_o,
  output logic              stop_o,
  output logic [WORD_W-1:0] rdata_o
);
  seq_st_e           state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] eba_q;
  logic              cs_q, trdy_q, stop_q, burst_q;
  logic [TMG_W-1:0]  tmg;
  logic              start, strobe, run;

  assign start = (state_q == ST_IDLE) && req_i && mem_en_i && rom_en_i;
  assign run   = (state_q == ST_FETCH);

  xrom_tmg_reg #(.TMG_W(TMG_W), .TMG_RST(TMG_RST)) i_tmg (
    .clk_i, .rst_ni, .we_i(tmg_we_i), .wd_i(tmg_wd_i), .tmg_o(tmg)
  );

  xrom_wait_ctr #(.TMG_W(TMG_W)) i_wait (
    .clk_i, .rst_ni, .load_i(start), .reload_i(tmg), .run_i(run), .strobe_o(strobe)
  );

  xrom_byte_gather #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_gather (
    .clk_i, .rst_ni, .cap_i(strobe), .idx_i(idx_q), .byte_i(ebd_i), .word_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      eba_q   <= '0;
      cs_q    <= 1'b0;
      trdy_q  <= 1'b0;
      stop_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (start) begin
            eba_q   <= {word_addr_i, IDX_W'(0)};
            idx_q   <= '0;
            burst_q <= burst_i;
            cs_q    <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (strobe) begin
            if (idx_q == IDX_W'(NBYTES - 1)) begin
              state_q <= ST_LAST;
            end else begin
              idx_q <= idx_q + 1'b1;
              // only the in-word offset steps
              eba_q <= {eba_q[ADDR_W-1:IDX_W], eba_q[IDX_W-1:0] + 1'b1};
            end
          end
        end
        ST_LAST: begin
          trdy_q  <= 1'b1;
          cs_q    <= 1'b0;
          state_q <= ST_RESP;
        end
        ST_RESP: begin
          trdy_q <= 1'b0;
          if (burst_q) begin
            stop_q  <= 1'b1;
            state_q <= ST_DISC;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DISC: begin
          stop_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign eba_o    = eba_q;
  assign rom_cs_o = cs_q;
  assign trdy_o   = trdy_q;
  assign stop_o   = stop_q;

  AST_TRDY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |=> !trdy_o); // R5
  AST_LAST_TO_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LAST) |=> trdy_o); // R5
  AST_CS_OFF_AT_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |-> !rom_cs_o); // R6
  AST_STOP_AFTER_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> ($past(trdy_o) && !trdy_o)); // R7
  AST_GATED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !(mem_en_i && rom_en_i)) |=> !rom_cs_o); // R8
  AST_ADDR_HI_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o && $past(rom_cs_o)) |-> eba_o[ADDR_W-1:IDX_W] == $past(eba_o[ADDR_W-1:IDX_W])); // R3
  AST_BUSY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !strobe) |=> state_q == ST_FETCH); // R10
endmodule

// File: tb/test_xrom_rd_seq.sv
`timescale 1ns/1ps
module test_xrom_rd_seq;
  localparam time CLK_P = 8ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_en_i = 1'b1, rom_en_i = 1'b1;
  logic        tmg_we_i = 1'b0;
  logic [3:0]  tmg_wd_i = '0;
  logic        req_i = 1'b0, burst_i = 1'b0;
  logic [5:0]  word_addr_i = '0;
  logic [7:0]  ebd_i = 8'hEE;
  logic [7:0]  eba_o;
  logic        rom_cs_o, trdy_o, stop_o;
  logic [31:0] rdata_o;

  int n_tests = 0, n_fail = 0;
  int n_cur = 9;

  always #(CLK_P/2) clk_i = ~clk_i;

  xrom_rd_seq i_xrom_rd_seq (
    .clk_i, .rst_ni, .mem_en_i, .rom_en_i, .tmg_we_i, .tmg_wd_i, .req_i,
    .burst_i, .word_addr_i, .ebd_i, .eba_o, .rom_cs_o, .trdy_o, .stop_o, .rdata_o
  );

  function automatic logic [7:0] rom_byte(logic [7:0] a);
    return a * 8'd7 + 8'h13;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ROM model: valid data only in the last cycle before the intended sample edge
  initial begin
    logic [7:0] last_a = 8'h00;
    logic       last_cs = 1'b0;
    int         age = 0;
    forever begin
      @(negedge clk_i);
      if (eba_o != last_a || (rom_cs_o && !last_cs)) age = 0;
      else if (age < 1000) age++;
      last_a  = eba_o;
      last_cs = rom_cs_o;
      ebd_i   = (age == n_cur) ? rom_byte(eba_o) : 8'hEE;
    end
  end

  task automatic write_tmg(logic [3:0] v);
    @(negedge clk_i);
    tmg_we_i = 1'b1; tmg_wd_i = v;
    @(negedge clk_i);
    tmg_we_i = 1'b0;
  endtask

  // one read; mid_tmg >= 0 writes timing at cycle 5; busy_req issues a second request at cycle 7
  task automatic do_read(string req, logic [5:0] wa, bit burst, int n, int mid_tmg, bit busy_req);
    logic [7:0]  base = {wa, 2'b00};
    logic [31:0] exp  = {rom_byte(base + 8'd3), rom_byte(base + 8'd2),
                         rom_byte(base + 8'd1), rom_byte(base)};
    int k = 0;
    int exp_k = 4 * (n + 1) + 1;
    bit seen = 1'b0;
    n_cur = n;
    @(negedge clk_i);
    req_i = 1'b1; word_addr_i = wa; burst_i = burst;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; burst_i = 1'b0;
    chk(eba_o == base, "R3", {req, " start address"}, eba_o, base);
    chk(rom_cs_o == 1'b1, "R6", {req, " cs at start"}, rom_cs_o, 1);
    while (!seen && k < 200) begin
      @(posedge clk_i);
      @(negedge clk_i);
      k++;
      if (k == 5 && mid_tmg >= 0) begin
        tmg_we_i = 1'b1; tmg_wd_i = 4'(mid_tmg);
      end else begin
        tmg_we_i = 1'b0;
      end
      if (k == 7 && busy_req) begin
        req_i = 1'b1; word_addr_i = wa ^ 6'h15;
      end else begin
        req_i = 1'b0;
      end
      if (trdy_o) seen = 1'b1;
      else if (!rom_cs_o) begin
        chk(1'b0, "R6", {req, " cs dropped early"}, k, exp_k);
        k = 200;
      end
    end
    tmg_we_i = 1'b0; req_i = 1'b0;
    chk(k == exp_k, "R5", {req, " trdy cycle"}, k, exp_k);
    chk(rdata_o == exp, "R4", {req, " read word"}, rdata_o, exp);
    chk(rom_cs_o == 1'b0, "R6", {req, " cs low with trdy"}, rom_cs_o, 0);
    chk(eba_o == base + 8'd3, "R3", {req, " final address"}, eba_o, base + 8'd3);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(stop_o == burst, "R7", {req, " stop after trdy"}, stop_o, burst);
    chk(trdy_o == 1'b0, "R7", {req, " no second trdy"}, trdy_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(stop_o == 1'b0, "R7", {req, " stop single cycle"}, stop_o, 0);
  endtask

  task automatic t_reset;
    chk(rom_cs_o == 1'b0 && trdy_o == 1'b0 && stop_o == 1'b0, "R6",
        "reset outputs", {rom_cs_o, trdy_o, stop_o}, 0);
  endtask

  task automatic t_default_timing;
    do_read("R1 R2 default", 6'h10, 1'b0, 9, -1, 1'b0);
  endtask

  task automatic t_timing_range;
    write_tmg(4'd0);
    do_read("R2 n0", 6'h20, 1'b0, 0, -1, 1'b0);
    write_tmg(4'd15);
    do_read("R2 n15", 6'h05, 1'b0, 15, -1, 1'b0);
  endtask

  task automatic t_addr_no_carry;
    write_tmg(4'd3);
    do_read("R3 top", 6'h3F, 1'b0, 3, -1, 1'b0);
  endtask

  task automatic t_mid_write;
    write_tmg(4'd6);
    do_read("R9 mid", 6'h11, 1'b0, 6, 2, 1'b0);
    do_read("R9 next", 6'h12, 1'b0, 2, -1, 1'b0);
  endtask

  task automatic t_burst;
    write_tmg(4'd1);
    do_read("R7 burst", 6'h22, 1'b1, 1, -1, 1'b0);
  endtask

  task automatic t_busy_req;
    bit quiet = 1'b1;
    write_tmg(4'd4);
    do_read("R10 busy", 6'h30, 1'b0, 4, -1, 1'b1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (rom_cs_o || trdy_o) quiet = 1'b0;
    end
    chk(quiet, "R10", "no access after dropped request", quiet, 1);
  endtask

  task automatic t_gating;
    write_tmg(4'd3);
    for (int c = 0; c < 3; c++) begin
      bit quiet = 1'b1;
      @(negedge clk_i);
      mem_en_i = c[0]; rom_en_i = c[1];
      req_i = 1'b1; word_addr_i = 6'h08;
      @(negedge clk_i);
      req_i = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk_i);
        if (rom_cs_o || trdy_o || stop_o) quiet = 1'b0;
      end
      chk(quiet, "R8", $sformatf("enables %0d ignored", c), quiet, 1);
    end
    @(negedge clk_i);
    mem_en_i = 1'b1; rom_en_i = 1'b1;
    do_read("R8 enabled", 6'h09, 1'b0, 3, -1, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_default_timing();
    t_timing_range();
    t_addr_no_carry();
    t_mid_write();
    t_burst();
    t_busy_req();
    t_gating();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule